// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block resolves one operand specifier of a 16-bit minicomputer-style CPU into either "the operand is a register" or a final 16-bit effective address. A specifier is a 3-bit addressing mode and a 3-bit register number. A byte/word flag comes with it. Of the eight general registers, the top one (index 7) is the program counter and the one below it (index 6) is the stack pointer.

The sequencer reads the register file through one combinational read port. It applies auto-increment and auto-decrement side effects through one registered write port. It fetches index words and indirect pointers with a request/acknowledge memory read. The instruction decoder pulses `start` with a specifier. The sequencer then works for a few cycles and answers with a one-cycle `done` pulse. At that pulse `reg_operand` and `ea` are valid. Program-counter forms (immediate, absolute, relative and relative-indirect) need no special decoding. They arise from the general modes applied to register 7.

Top module: `opnd_ea_seq`

## Requirements
- R1: Mode 0 finishes with `done` and `reg_operand`=1. It makes no memory read and no register write.
- R2: Mode 1 finishes with `reg_operand`=0 and `ea` equal to the selected register. It makes no memory read and no register write.
- R3: Mode 2 (post-increment) gives `ea` equal to the old register value and then adds the step to the register. The step is 1 for a byte operation on registers 0 to 5 and 2 in every other case.
- R4: Mode 3 reads memory at the register value, returns the fetched word as `ea`, and adds 2 to the register.
- R5: Mode 4 (pre-decrement) subtracts the step defined in R3 from the register and gives the new value as `ea`.
- R6: Mode 5 subtracts 2 from the register, reads memory at the new value, and returns the fetched word as `ea`.
- R7: Mode 6 reads an index word X at the current PC and writes PC+2 back. `ea` is then base+X, where the base is the selected register, or the advanced PC when the register is 7.
- R8: Mode 7 forms the same sum as R7, reads memory at that sum, and returns the fetched word as `ea`.
- R9: With register 7, mode 2 gives `ea` equal to the PC (an immediate word) and mode 3 gives `ea` equal to the word at the PC (an absolute address). Both advance the PC by 2, even for byte operations.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen, and the sequencer makes no progress past a read until then.
- R11: Each specifier causes at most one register write. Modes 0 and 1 cause none; modes 2 to 7 cause exactly one.
- R12: `done` is a single-cycle pulse. A `start` that arrives while `busy` is high is ignored and does not change the result.
- R13: After reset, `busy`, `done`, `mem_req` and `rf_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving the specifier on the spec inputs |
| spec_mode | input | 3 | Addressing mode 0..7 |
| spec_reg | input | 3 | Register number 0..7 (7 = PC, 6 = SP) |
| byte_op | input | 1 | 1 for a byte operand, 0 for a word operand |
| busy | output | 1 | Sequencer is working on a specifier |
| rf_raddr | output | 3 | Register-file read select |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write select |
| rf_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge; data valid in the same cycle |
| mem_rdata | input | 16 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| reg_operand | output | 1 | Operand is the register itself (valid with done) |
| ea | output | 16 | Effective address (valid with done when reg_operand is 0) |

## Verification
The bench targets the step size. It pairs byte operations on ordinary registers with byte operations on the stack pointer and the PC, and with deferred modes. A design that stepped by one in the wrong place would leave a register off by one. Relative modes on register 7 check that the base is the PC after the index fetch. A design that used the stale PC would produce an address two lower. Memory latency is varied from zero to several cycles to expose any design that moves on before `mem_ack` or that changes the address while waiting. A second `start` is pulsed mid-operation to catch a design that restarts or latches the new specifier.

// File: rtl/oea_pkg.sv
package oea_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_XWAIT = 3'd2,
    ST_SUM   = 3'd3,
    ST_PWAIT = 3'd4
  } oea_state_t;

  localparam logic [2:0] AM_REG  = 3'd0;
  localparam logic [2:0] AM_DEF  = 3'd1;
  localparam logic [2:0] AM_INC  = 3'd2;
  localparam logic [2:0] AM_INCD = 3'd3;
  localparam logic [2:0] AM_DEC  = 3'd4;
  localparam logic [2:0] AM_DECD = 3'd5;
  localparam logic [2:0] AM_IDX  = 3'd6;
  localparam logic [2:0] AM_IDXD = 3'd7;

endpackage

// File: rtl/oea_step_unit.sv
module oea_step_unit #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic [DW-1:0]  base,
  input  logic [2:0]     mode,
  input  logic [RAW-1:0] rsel,
  input  logic           byte_op,
  output logic [DW-1:0]  inc_val,
  output logic [DW-1:0]  dec_val
);
  localparam logic [RAW-1:0] SP_IDX = RAW'(NREG - 2);

  logic          full_step;
  logic [DW-1:0] step;

  // Deferred modes carry mode[0]=1 (3 and 5) and always move a whole word.
  always_comb begin
    full_step = mode[0] || (rsel >= SP_IDX) || !byte_op;
    step      = full_step ? DW'(2) : DW'(1);
    inc_val   = base + step;
    dec_val   = base - step;
  end

endmodule

// File: rtl/oea_mem_port.sv
module oea_mem_port #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [AW-1:0] launch_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data
);
  logic          req_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else if (launch) begin
      req_q  <= 1'b1;
      addr_q <= launch_addr;
    end else if (req_q && mem_ack) begin
      req_q  <= 1'b0;
    end
  end

  assign mem_req    = req_q;
  assign mem_addr   = addr_q;
  assign resp_valid = req_q && mem_ack;
  assign resp_data  = mem_rdata;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    launch |-> !mem_req);

endmodule

// File: rtl/oea_result.sv
module oea_result #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fin,
  input  logic          fin_regop,
  input  logic [DW-1:0] fin_ea,
  output logic          done,
  output logic          reg_operand,
  output logic [DW-1:0] ea
);
  logic          done_q;
  logic          regop_q;
  logic [DW-1:0] ea_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      regop_q <= 1'b0;
      ea_q    <= '0;
    end else begin
      done_q <= fin;
      if (fin) begin
        regop_q <= fin_regop;
        ea_q    <= fin_ea;
      end
    end
  end

  assign done        = done_q;
  assign reg_operand = regop_q;
  assign ea          = ea_q;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/opnd_ea_seq.sv
module opnd_ea_seq #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     spec_mode,
  input  logic [RAW-1:0] spec_reg,
  input  logic           byte_op,
  output logic           busy,
  output logic [RAW-1:0] rf_raddr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [RAW-1:0] rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done,
  output logic           reg_operand,
  output logic [DW-1:0]  ea
);
  import oea_pkg::*;

  localparam logic [RAW-1:0] PC_IDX = RAW'(NREG - 1);
  localparam logic [DW-1:0]  WSTEP  = DW'(2);

  oea_state_t     st_q, st_d;
  logic [2:0]     mode_q;
  logic [RAW-1:0] rsel_q;
  logic           byte_q;
  logic [DW-1:0]  pc_snap_q;
  logic [DW-1:0]  x_q;

  logic           we_q;
  logic [RAW-1:0] waddr_q;
  logic [DW-1:0]  wdata_q;

  logic           we_d;
  logic [RAW-1:0] waddr_d;
  logic [DW-1:0]  wdata_d;

  logic           launch;
  logic [DW-1:0]  launch_addr;
  logic           resp_valid;
  logic [DW-1:0]  resp_data;

  logic           fin;
  logic           fin_regop;
  logic [DW-1:0]  fin_ea;

  logic [DW-1:0]  inc_val;
  logic [DW-1:0]  dec_val;
  logic [DW-1:0]  idx_base;
  logic [DW-1:0]  idx_sum;
  logic           is_indexed;

  assign is_indexed = (mode_q == AM_IDX) || (mode_q == AM_IDXD);

  // Index modes read the PC first (extension word), otherwise the named register.
  always_comb begin
    if (st_q == ST_EVAL && is_indexed) rf_raddr = PC_IDX;
    else                               rf_raddr = rsel_q;
  end

  // After the extension fetch the PC write is still in flight, so the
  // relative base is formed from the snapshot instead of a re-read.
  assign idx_base = (rsel_q == PC_IDX) ? (pc_snap_q + WSTEP) : rf_rdata;
  assign idx_sum  = idx_base + x_q;

  oea_step_unit #(.DW(DW), .NREG(NREG)) u_step (
    .base    (rf_rdata),
    .mode    (mode_q),
    .rsel    (rsel_q),
    .byte_op (byte_q),
    .inc_val (inc_val),
    .dec_val (dec_val)
  );

  always_comb begin
    st_d        = st_q;
    launch      = 1'b0;
    launch_addr = '0;
    we_d        = 1'b0;
    waddr_d     = rsel_q;
    wdata_d     = '0;
    fin         = 1'b0;
    fin_regop   = 1'b0;
    fin_ea      = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) st_d = ST_EVAL;
      end
      ST_EVAL: begin
        unique case (mode_q)
          AM_REG: begin
            fin       = 1'b1;
            fin_regop = 1'b1;
            st_d      = ST_IDLE;
          end
          AM_DEF: begin
            fin    = 1'b1;
            fin_ea = rf_rdata;
            st_d   = ST_IDLE;
          end
          AM_INC: begin
            we_d    = 1'b1;
            wdata_d = inc_val;
            fin     = 1'b1;
            fin_ea  = rf_rdata;
            st_d    = ST_IDLE;
          end
          AM_INCD: begin
            we_d        = 1'b1;
            wdata_d     = inc_val;
            launch      = 1'b1;
            launch_addr = rf_rdata;
            st_d        = ST_PWAIT;
          end
          AM_DEC: begin
            we_d    = 1'b1;
            wdata_d = dec_val;
            fin     = 1'b1;
            fin_ea  = dec_val;
            st_d    = ST_IDLE;
          end
          AM_DECD: begin
            we_d        = 1'b1;
            wdata_d     = dec_val;
            launch      = 1'b1;
            launch_addr = dec_val;
            st_d        = ST_PWAIT;
          end
          default: begin
            launch      = 1'b1;
            launch_addr = rf_rdata;
            st_d        = ST_XWAIT;
          end
        endcase
      end
      ST_XWAIT: begin
        if (resp_valid) begin
          we_d    = 1'b1;
          waddr_d = PC_IDX;
          wdata_d = pc_snap_q + WSTEP;
          st_d    = ST_SUM;
        end
      end
      ST_SUM: begin
        if (mode_q == AM_IDXD) begin
          launch      = 1'b1;
          launch_addr = idx_sum;
          st_d        = ST_PWAIT;
        end else begin
          fin    = 1'b1;
          fin_ea = idx_sum;
          st_d   = ST_IDLE;
        end
      end
      ST_PWAIT: begin
        if (resp_valid) begin
          fin    = 1'b1;
          fin_ea = resp_data;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      mode_q    <= AM_REG;
      rsel_q    <= '0;
      byte_q    <= 1'b0;
      pc_snap_q <= '0;
      x_q       <= '0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      st_q    <= st_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      if (st_q == ST_IDLE && start) begin
        mode_q <= spec_mode;
        rsel_q <= spec_reg;
        byte_q <= byte_op;
      end
      if (st_q == ST_EVAL && is_indexed) pc_snap_q <= rf_rdata;
      if (st_q == ST_XWAIT && resp_valid) x_q <= resp_data;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign rf_we    = we_q;
  assign rf_waddr = waddr_q;
  assign rf_wdata = wdata_q;

  oea_mem_port #(.AW(DW), .DW(DW)) u_mem (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_addr (launch_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .resp_valid  (resp_valid),
    .resp_data   (resp_data)
  );

  oea_result #(.DW(DW)) u_res (
    .clk         (clk),
    .rst         (rst),
    .fin         (fin),
    .fin_regop   (fin_regop),
    .fin_ea      (fin_ea),
    .done        (done),
    .reg_operand (reg_operand),
    .ea          (ea)
  );

  // R1
  regop_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (done && reg_operand) |-> (mode_q == AM_REG));

  // R11
  wr_target_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr == rsel_q || rf_waddr == PC_IDX));

  // R11
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q) && $stable(rsel_q));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

endmodule

// File: tb/tb_opnd_ea_seq.sv
module tb_opnd_ea_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  spec_mode = '0;
  logic [2:0]  spec_reg = '0;
  logic        byte_op = 1'b0;
  logic        busy;
  logic [2:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done;
  logic        reg_operand;
  logic [15:0] ea;

  logic [15:0] regs [8];
  int          n_chk = 0;
  int          n_bad = 0;
  int          wr_cnt = 0;
  int          lat_cfg = 0;
  int          wait_cnt = 0;
  int          cyc = 0;
  logic [15:0] held_addr = '0;
  logic [15:0] exp_rd [$];
  string       cur_tag = "R1";

  always #2 clk = ~clk;

  opnd_ea_seq dut (
    .clk(clk), .rst(rst), .start(start), .spec_mode(spec_mode),
    .spec_reg(spec_reg), .byte_op(byte_op), .busy(busy),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .reg_operand(reg_operand), .ea(ea)
  );

  assign rf_rdata = regs[rf_raddr];

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  function automatic string tag_of(input logic [2:0] m, input logic [2:0] r);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return (r == 3'd7) ? "R9" : "R3";
      3'd3: return (r == 3'd7) ? "R9" : "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Register file write port model
  always @(posedge clk) begin
    cyc++;
    if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
      wr_cnt++;
    end
  end

  // Memory responder: checks every request against the model's queue
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        if (exp_rd.size() == 0) begin
          check(cur_tag, "unexpected read", {16'h0, mem_addr}, 32'hFFFF_FFFF);
        end else begin
          check(cur_tag, "read address", {16'h0, mem_addr}, {16'h0, exp_rd.pop_front()});
        end
      end else if (mem_addr !== held_addr) begin
        check("R10", "address moved while waiting", {16'h0, mem_addr}, {16'h0, held_addr});
      end
      held_addr = mem_addr;
      if (wait_cnt >= lat_cfg) begin
        mem_ack = 1'b1;
        mem_rdata = memf(mem_addr);
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic run_op(input logic [2:0] m, input logic [2:0] r,
                        input logic b, input int lat, input bit poke);
    logic [15:0] exp_regs [8];
    logic [15:0] rv, pc, x, base, s, exp_ea;
    logic        exp_regop;
    int          exp_wr;
    int          st;
    int          w0;
    bit          got;
    for (int i = 0; i < 8; i++) exp_regs[i] = regs[i];
    rv = regs[r];
    exp_regop = 1'b0;
    exp_ea = '0;
    exp_wr = 1;
    st = (r >= 3'd6 || !b) ? 2 : 1;
    exp_rd.delete();
    case (m)
      3'd0: begin exp_regop = 1'b1; exp_wr = 0; end
      3'd1: begin exp_ea = rv; exp_wr = 0; end
      3'd2: begin exp_ea = rv; exp_regs[r] = rv + 16'(st); end
      3'd3: begin exp_rd.push_back(rv); exp_ea = memf(rv); exp_regs[r] = rv + 16'd2; end
      3'd4: begin exp_ea = rv - 16'(st); exp_regs[r] = exp_ea; end
      3'd5: begin
        exp_regs[r] = rv - 16'd2;
        exp_rd.push_back(exp_regs[r]);
        exp_ea = memf(exp_regs[r]);
      end
      default: begin
        pc = regs[7];
        exp_rd.push_back(pc);
        x = memf(pc);
        exp_regs[7] = pc + 16'd2;
        base = (r == 3'd7) ? pc + 16'd2 : regs[r];
        s = base + x;
        if (m == 3'd6) exp_ea = s;
        else begin exp_rd.push_back(s); exp_ea = memf(s); end
      end
    endcase
    cur_tag = tag_of(m, r);
    lat_cfg = lat;
    w0 = wr_cnt;
    @(negedge clk);
    start = 1'b1; spec_mode = m; spec_reg = r; byte_op = b;
    got = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin got = 1'b1; break; end
      if (poke && k == 0) begin
        // R12: a second start while busy must not disturb the operation
        start = 1'b1; spec_mode = ~m; spec_reg = ~r; byte_op = ~b;
      end
    end
    start = 1'b0;
    check(cur_tag, "done seen", {31'h0, got}, 32'h1);
    check(cur_tag, "reg_operand", {31'h0, reg_operand}, {31'h0, exp_regop});
    if (!exp_regop) check(cur_tag, "ea", {16'h0, ea}, {16'h0, exp_ea});
    @(negedge clk);
    check("R12", "done is one cycle", {31'h0, done}, 32'h0);
    check("R12", "idle after done", {31'h0, busy}, 32'h0);
    for (int i = 0; i < 8; i++)
      check(cur_tag, $sformatf("reg %0d after op", i), {16'h0, regs[i]}, {16'h0, exp_regs[i]});
    check(cur_tag, "pending reads", exp_rd.size(), 0);
    check("R11", "register writes", wr_cnt - w0, exp_wr);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] <= 16'h1000 + 16'(i * 16'h0111);
    regs[6] <= 16'h0F00;
    regs[7] <= 16'h0400;
    repeat (3) @(negedge clk);
    check("R13", "busy at reset", {31'h0, busy}, 32'h0);
    check("R13", "done at reset", {31'h0, done}, 32'h0);
    check("R13", "mem_req at reset", {31'h0, mem_req}, 32'h0);
    check("R13", "rf_we at reset", {31'h0, rf_we}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    run_op(3'd0, 3'd3, 1'b0, 0, 1'b0);
    run_op(3'd1, 3'd1, 1'b0, 0, 1'b0);
    run_op(3'd2, 3'd0, 1'b1, 0, 1'b0);
    run_op(3'd2, 3'd0, 1'b0, 0, 1'b0);
    run_op(3'd2, 3'd6, 1'b1, 0, 1'b0);
    run_op(3'd4, 3'd2, 1'b1, 0, 1'b0);
    run_op(3'd4, 3'd6, 1'b1, 0, 1'b0);
    run_op(3'd3, 3'd4, 1'b1, 2, 1'b0);
    run_op(3'd5, 3'd5, 1'b1, 1, 1'b0);
    run_op(3'd6, 3'd1, 1'b0, 2, 1'b0);
    run_op(3'd7, 3'd2, 1'b0, 3, 1'b0);
    run_op(3'd2, 3'd7, 1'b1, 0, 1'b0);
    run_op(3'd3, 3'd7, 1'b0, 1, 1'b0);
    run_op(3'd6, 3'd7, 1'b0, 0, 1'b0);
    run_op(3'd7, 3'd7, 1'b1, 4, 1'b0);
    run_op(3'd7, 3'd3, 1'b0, 2, 1'b1);
    run_op(3'd4, 3'd1, 1'b1, 0, 1'b1);
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 6; r++)
        run_op(3'(m), 3'(r), 1'((m + r) % 2), (m * 3 + r) % 4, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule